// File: doc/BRIEF.md
# Flash thermometer-to-binary encoder through a Gray stage

This block sits behind the comparator bank of a 6-bit flash converter. Each sample arrives as a 63-bit thermometer word. Tap 1 is the lowest threshold and sits on bit 0 of the input bus. The block returns the binary count of the level the input crossed. It works in two steps.

First, every tap feeds exactly one Gray bit. A tap at position m belongs to the Gray bit whose index equals the number of trailing zeros of m. That Gray bit is the XOR of all the taps assigned to it, so the top Gray bit is tap 32 alone. Second, a prefix XOR from the top turns the Gray word into binary.

Because no tap reaches two Gray bits, one misplaced comparator can corrupt only one Gray bit. The size of the error is therefore fixed by where the bubble sits. Bubbles at odd taps are off by one code at most.

The input word is registered when a valid strobe comes with it. The binary result is registered with its own strobe two clock cycles later. A new sample can enter every cycle.

Top module: `therm_gray_enc`

## Requirements
- R1: When the input has the form of a thermometer (taps 1..n high and the rest low, tap k on bus bit k-1), the output code equals n for every n from 0 to 63.
- R2: An all-low input gives code 0, and an all-high input gives code 63.
- R3: If exactly one tap m of a valid n-level word is inverted, the code equals n XOR (2^(t+1) - 1), where t is the number of trailing zeros of m. For any odd m, the code therefore differs from n by exactly one.
- R4: out_valid rises exactly two rising clock edges after an edge that samples in_valid high. The result belongs to the word sampled at that edge. Back-to-back samples come out one per cycle, in order.
- R5: Input words presented while in_valid is low are ignored. While out_valid is low, code keeps its last value.
- R6: While rst_n is low, out_valid and code are held at 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the current thermometer word as a sample |
| therm | input | 63 | Comparator outputs; bit k-1 is tap k, lowest threshold at bit 0 |
| out_valid | output | 1 | High for one cycle for each finished conversion |
| code | output | 6 | Binary result, held between conversions |

## Verification
The Gray stage has no state of its own, so a wrong tap assignment shows up in the very next result. It appears two edges after the bad word enters. The error pattern gives the fault away: a wrong mask for Gray bit t inverts exactly the low t+1 code bits, only on the levels that cross that tap. A wrong strobe stage or a load that ignores the strobe shows up as a shifted or repeated result in the back-to-back sweep. It is visible on the first sample that follows the fault.

// File: rtl/therm_gray_enc.sv
module therm_gray_enc #(
  parameter int NBITS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [2**NBITS-2:0]    therm,
  output logic                   out_valid,
  output logic [NBITS-1:0]       code
);
  localparam int NTAP = 2**NBITS - 1;

  // taps whose index has exactly k trailing zeros feed Gray bit k
  function automatic logic [NTAP-1:0] tap_mask(input int k);
    logic [NTAP-1:0] res;
    res = '0;
    for (int m = 1; m <= NTAP; m++)
      res[m-1] = (((m >> k) & 1) == 1) && ((m % (1 << k)) == 0);
    return res;
  endfunction

  logic [NTAP-1:0]  therm_q;
  logic             vld_q;
  logic [NBITS-1:0] gray;
  logic [NBITS-1:0] bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) therm_q <= therm;
    end
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_gray
    assign gray[k] = ^(therm_q & tap_mask(k));
    assign bin[k]  = ^gray[NBITS-1:k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      code      <= '0;
    end else begin
      out_valid <= vld_q;
      if (vld_q) code <= bin;
    end
  end
endmodule

module therm_gray_enc_chk #(
  parameter int NBITS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2**NBITS-2:0] therm,
  input logic                out_valid,
  input logic [NBITS-1:0]    code
);
  a_r1_level_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (($past(therm, 2) & ($past(therm, 2) + 1'b1)) == '0))
      |-> code == NBITS'($countones($past(therm, 2))));

  a_r2_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(&therm, 2)) |-> &code);

  a_r4_latency_in: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r4_latency_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(code));

  a_r6_reset: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && code == '0));
endmodule

bind therm_gray_enc therm_gray_enc_chk #(.NBITS(NBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .therm(therm),
  .out_valid(out_valid), .code(code)
);

// File: tb/therm_gray_enc_tb.sv
module therm_gray_enc_tb_top;
  localparam int NBITS = 6;
  localparam int NTAP  = 2**NBITS - 1;

  // bubble table: level, inverted tap (0 = none), expected code per R3
  localparam int NB = 10;
  localparam int B_LVL[NB] = '{0, 63, 40, 10, 20, 50,  7, 33, 1, 62};
  localparam int B_POS[NB] = '{0,  0,  5, 13, 18, 12,  8, 32, 2, 63};
  localparam int B_EXP[NB] = '{0, 63, 41, 11, 23, 53,  8, 30, 2, 63};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NTAP-1:0] therm = '0;
  logic out_valid;
  logic [NBITS-1:0] code;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  therm_gray_enc #(.NBITS(NBITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .therm(therm),
    .out_valid(out_valid), .code(code)
  );

  function automatic logic [NTAP-1:0] mk(input int lvl, input int pos);
    logic [NTAP-1:0] v;
    for (int i = 0; i < NTAP; i++) v[i] = (i < lvl);
    if (pos > 0) v[pos-1] = ~v[pos-1];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic one_shot(input logic [NTAP-1:0] w, input int exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; therm = w;
    @(negedge clk);
    in_valid = 1'b0; therm = ~w;
    @(negedge clk);
    check(out_valid === 1'b1, "R4 valid", int'(out_valid), 1);
    check(code === exp[NBITS-1:0], req, int'(code), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check(out_valid === 1'b0 && code === '0, "R6 reset", int'(code), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NB; i++)
      one_shot(mk(B_LVL[i], B_POS[i]), B_EXP[i], (B_POS[i] == 0) ? "R2 scale" : "R3 bubble");

    // R5: ignored words and held code
    @(negedge clk);
    therm = mk(17, 0); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R5 no strobe", int'(out_valid), 0);
    check(code === 6'd63, "R5 hold", int'(code), 63);

    // R1/R4: every level back to back
    for (int i = 0; i < NTAP + 3; i++) begin
      @(negedge clk);
      if (i >= 2 && i < NTAP + 3) begin
        check(out_valid === 1'b1, "R4 stream", int'(out_valid), 1);
        check(code === NBITS'(i - 2), "R1 level", int'(code), i - 2);
      end
      if (i <= NTAP) begin in_valid = 1'b1; therm = mk(i, 0); end
      else begin in_valid = 1'b0; therm = '0; end
    end
    @(negedge clk);
    check(out_valid === 1'b0, "R4 drain", int'(out_valid), 0);
    check(code === 6'd63, "R5 hold after stream", int'(code), 63);

    // R6: asynchronous reset with data in flight
    @(negedge clk);
    in_valid = 1'b1; therm = mk(45, 0);
    @(negedge clk);
    in_valid = 1'b0;
    #2 rst_n = 1'b0;
    #1 check(out_valid === 1'b0 && code === '0, "R6 async", int'(code), 0);
    @(negedge clk);
    check(out_valid === 1'b0 && code === '0, "R6 flushed", int'(code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R6 no stale result", int'(out_valid), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule